// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer with Keyboard-Reset Pulse

This block is a watchdog timer that software drives through three byte-wide configuration registers on a simple register bus. These are a count register, a control register and a status register. Writing a nonzero value to the count register loads it and starts the timer. Writing it again restarts the timer from the new value, and that write is the keep-alive action. From then on the same register holds the time still left. Writing zero stops the timer.

A parameterised prescaler turns the system clock into a one-second tick. The count drops by one on each tick, or once every `SECS_PER_MIN` ticks when minute mode is selected. When the count reaches zero it stays there. The block then sets a timeout flag and drives the active-low watchdog output low. That output stays low until software clears the flag or writes a new nonzero count. A control bit can also send a fixed-length low pulse to a keyboard-reset output at the moment of expiry.

Two single-wire activity inputs, keyboard and mouse, act on a running timer. Keyboard activity can stop it. Either input can reload it with the last nonzero value written to the count register.

Top module: `tick_watchdog`

## Requirements
- R1: After a synchronous reset, all three registers read 0, `wdt_out_n` is 1 and `kbrst_n` is 1.
- R2: A write of a nonzero N to the count address (0xF6) loads N and restarts the prescaler. In seconds mode the count then falls by one every `TICK_DIV` clocks, and a read of 0xF6 returns the remaining count.
- R3: Writing 0 to the count register stops the timer: the count stays 0 and no expiry occurs.
- R4: When the count steps from 1 to 0, the count holds at 0 and status bit 4 is set. `wdt_out_n` goes low in the same clock and stays low until a status write with bit 4 = 0 or a nonzero count write.
- R5: When control bit 1 (address 0xF5) is 1, an expiry drives `kbrst_n` low for exactly `PULSE_CYCLES` clocks. When control bit 1 is 0, `kbrst_n` stays 1 on expiry.
- R6: When control bit 3 is 1 (minute mode), each count step takes `SECS_PER_MIN` × `TICK_DIV` clocks.
- R7: When control bit 2 is 1, a cycle with `kbd_act` high on a running timer forces the count to 0 without setting the flag. When control bit 2 is 0, `kbd_act` does not stop the timer. A stop takes priority over a reload.
- R8: Status bit 6 (keyboard) and bit 7 (mouse) each let a cycle of the matching activity input reload a running timer with the last nonzero value written. With both bits clear, activity has no effect. A count write takes priority over any activity event in the same cycle.
- R9: Reads return data one clock after `bus_re`. Control reads back bits 3:1 with the other bits 0. Status reads back bits 7, 6 and 4 with the other bits 0. Any address other than 0xF5, 0xF6 and 0xF7 reads 0.
- R10: A status write with bit 4 = 1 neither sets nor clears the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data appears the next cycle |
| bus_rdata | output | 8 | Registered read data |
| kbd_act | input | 1 | Keyboard activity, one-cycle event |
| mouse_act | input | 1 | Mouse activity, one-cycle event |
| wdt_out_n | output | 1 | Active-low watchdog output, low while the timeout flag is set |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The bench builds the block with `TICK_DIV` = 4, `SECS_PER_MIN` = 5 and `PULSE_CYCLES` = 16. With these values every count step is four clocks and a minute step is twenty, so the bench can sweep every start value from 1 to 32, plus 255, and compare each expiry clock exactly with N × 4. The short tick also lets the bench place activity events, flag clears and reads on exact clock offsets within a step. It can therefore check reload timing, stop priority and the full width of the keyboard-reset pulse cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 8;

  // control register fields
  localparam int CTL_KBRST_BIT  = 1;
  localparam int CTL_KBSTOP_BIT = 2;
  localparam int CTL_MINUTE_BIT = 3;

  // status register fields
  localparam int STS_FLAG_BIT  = 4;
  localparam int STS_KBRL_BIT  = 6;
  localparam int STS_MSRL_BIT  = 7;

  typedef logic [REG_W-1:0] reg_t;

  typedef struct packed {
    logic minute;
    logic kb_stop;
    logic kbrst_en;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'hF5,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 'hF6,
  parameter logic [ADDR_W-1:0] STS_ADDR = 'hF7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  reg_t              bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output reg_t              bus_rdata,
  input  reg_t              cnt_i,
  input  logic              expire_i,
  output logic              cnt_wr_o,
  output ctrl_t             ctl_o,
  output logic              kbd_rl_o,
  output logic              mouse_rl_o,
  output logic              flag_o
);
  logic  ctl_wr, sts_wr;
  ctrl_t ctl_q;
  logic  kbd_rl_q, mouse_rl_q, flag_q;
  reg_t  rd_mux, rdata_q;

  assign ctl_wr   = bus_we && (bus_addr == CTL_ADDR);
  assign sts_wr   = bus_we && (bus_addr == STS_ADDR);
  assign cnt_wr_o = bus_we && (bus_addr == CNT_ADDR);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CTL_ADDR) begin
      rd_mux[CTL_MINUTE_BIT] = ctl_q.minute;
      rd_mux[CTL_KBSTOP_BIT] = ctl_q.kb_stop;
      rd_mux[CTL_KBRST_BIT]  = ctl_q.kbrst_en;
    end else if (bus_addr == CNT_ADDR) begin
      rd_mux = cnt_i;
    end else if (bus_addr == STS_ADDR) begin
      rd_mux[STS_MSRL_BIT] = mouse_rl_q;
      rd_mux[STS_KBRL_BIT] = kbd_rl_q;
      rd_mux[STS_FLAG_BIT] = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      kbd_rl_q   <= 1'b0;
      mouse_rl_q <= 1'b0;
      flag_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_q.minute   <= bus_wdata[CTL_MINUTE_BIT];
        ctl_q.kb_stop  <= bus_wdata[CTL_KBSTOP_BIT];
        ctl_q.kbrst_en <= bus_wdata[CTL_KBRST_BIT];
      end
      if (sts_wr) begin
        kbd_rl_q   <= bus_wdata[STS_KBRL_BIT];
        mouse_rl_q <= bus_wdata[STS_MSRL_BIT];
      end
      if (expire_i)
        flag_q <= 1'b1;
      else if (cnt_wr_o && (bus_wdata != '0))
        flag_q <= 1'b0;
      else if (sts_wr && !bus_wdata[STS_FLAG_BIT])
        flag_q <= 1'b0;
      if (bus_re)
        rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign ctl_o      = ctl_q;
  assign kbd_rl_o   = kbd_rl_q;
  assign mouse_rl_o = mouse_rl_q;
  assign flag_o     = flag_q;

  // R4: an expiry always leaves the flag set in the next cycle
  a_r4_flag_on_expiry: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> flag_q);

  // R10: writing a one to the flag position keeps a set flag
  a_r10_flag_kept: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && bus_wdata[STS_FLAG_BIT] && flag_q) |=> flag_q);
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int TICK_DIV     = 50_000_000,
  parameter int SECS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic minute_i,
  output logic step_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;

  logic sec_tick;

  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || restart_i)
          pre_q <= '0;
        else if (pre_q == PW'(TICK_DIV - 1))
          pre_q <= '0;
        else
          pre_q <= pre_q + 1'b1;
      end
      assign sec_tick = !restart_i && (pre_q == PW'(TICK_DIV - 1));

      // R2: seconds ticks are never back to back when the divider exceeds one
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);
    end else begin : g_nopre
      assign sec_tick = !restart_i;
    end
  endgenerate

  logic [MW-1:0] min_q;
  logic          unit_end;

  assign unit_end = !minute_i || (min_q == MW'(SECS_PER_MIN - 1));

  always_ff @(posedge clk) begin
    if (rst || restart_i)
      min_q <= '0;
    else if (sec_tick) begin
      if (unit_end)
        min_q <= '0;
      else
        min_q <= min_q + 1'b1;
    end
  end

  assign step_o = sec_tick && unit_end;

  // R6: in seconds mode the minute divider stays parked at zero
  a_r6_min_parked: assert property (@(posedge clk) disable iff (rst)
    (!minute_i && sec_tick) |=> (min_q == '0));
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  reg_t wdata_i,
  input  logic step_i,
  input  logic kbd_i,
  input  logic mouse_i,
  input  logic kb_stop_en_i,
  input  logic kbd_rl_en_i,
  input  logic mouse_rl_en_i,
  output reg_t cnt_o,
  output logic running_o,
  output logic kick_o,
  output logic expire_o
);
  reg_t cnt_q, rl_q;
  logic running, kb_stop, reload;

  assign running = (cnt_q != '0);
  assign kb_stop = running && kb_stop_en_i && kbd_i;
  assign reload  = running && ((kbd_rl_en_i && kbd_i) || (mouse_rl_en_i && mouse_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
      if (wdata_i != '0)
        rl_q <= wdata_i;
    end else if (kb_stop) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= rl_q;
    end else if (step_i && running) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = running;
  assign kick_o    = (wr_i && (wdata_i != '0)) || (!wr_i && !kb_stop && reload);
  assign expire_o  = step_i && (cnt_q == reg_t'(1)) && !wr_i && !kb_stop && !reload;

  // R2: an undisturbed step lowers the count by exactly one
  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (step_i && running && !wr_i && !kb_stop && !reload) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: a stopped timer stays stopped without a write
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!running && !wr_i) |=> (cnt_q == '0));

  // R7: keyboard stop empties the count
  a_r7_kbd_stop: assert property (@(posedge clk) disable iff (rst)
    (kb_stop && !wr_i) |=> (cnt_q == '0));

  // R8: reload restores the last nonzero value written
  a_r8_reload_value: assert property (@(posedge clk) disable iff (rst)
    (reload && !kb_stop && !wr_i) |=> (cnt_q == $past(rl_q)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic low_o
);
  localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic [CW-1:0] left_q;
  logic          low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= 1'b0;
      left_q <= '0;
    end else if (start_i) begin
      low_q  <= 1'b1;
      left_q <= CW'(PULSE_CYCLES - 1);
    end else if (low_q) begin
      if (left_q == '0)
        low_q <= 1'b0;
      else
        left_q <= left_q - 1'b1;
    end
  end

  assign low_o = low_q;

  // R5: a pulse with cycles left does not end early
  a_r5_pulse_holds: assert property (@(posedge clk) disable iff (rst)
    (low_q && (left_q != '0)) |=> low_q);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdt_pkg::*;
#(
  parameter int TICK_DIV     = 50_000_000,
  parameter int SECS_PER_MIN = 60,
  parameter int PULSE_CYCLES = 16,
  parameter int ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'hF5,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 'hF6,
  parameter logic [ADDR_W-1:0] STS_ADDR = 'hF7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic              kbd_act,
  input  logic              mouse_act,
  output logic              wdt_out_n,
  output logic              kbrst_n
);
  reg_t  cnt;
  logic  cnt_wr, expire, running, kick, step;
  ctrl_t ctl;
  logic  kbd_rl, mouse_rl, flag, kb_low;

  wdt_regs #(
    .ADDR_W  (ADDR_W),
    .CTL_ADDR(CTL_ADDR),
    .CNT_ADDR(CNT_ADDR),
    .STS_ADDR(STS_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .cnt_i     (cnt),
    .expire_i  (expire),
    .cnt_wr_o  (cnt_wr),
    .ctl_o     (ctl),
    .kbd_rl_o  (kbd_rl),
    .mouse_rl_o(mouse_rl),
    .flag_o    (flag)
  );

  wdt_tick #(
    .TICK_DIV    (TICK_DIV),
    .SECS_PER_MIN(SECS_PER_MIN)
  ) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart_i(kick || !running),
    .minute_i (ctl.minute),
    .step_o   (step)
  );

  wdt_count u_count (
    .clk          (clk),
    .rst          (rst),
    .wr_i         (cnt_wr),
    .wdata_i      (bus_wdata),
    .step_i       (step),
    .kbd_i        (kbd_act),
    .mouse_i      (mouse_act),
    .kb_stop_en_i (ctl.kb_stop),
    .kbd_rl_en_i  (kbd_rl),
    .mouse_rl_en_i(mouse_rl),
    .cnt_o        (cnt),
    .running_o    (running),
    .kick_o       (kick),
    .expire_o     (expire)
  );

  wdt_pulse #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .start_i(expire && ctl.kbrst_en),
    .low_o  (kb_low)
  );

  assign wdt_out_n = !flag;
  assign kbrst_n   = !kb_low;

  // R4: the watchdog output only falls together with an expiry
  a_r4_out_falls_on_expiry: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_out_n) |-> (cnt == '0));
endmodule

// File: tb/tb_tick_watchdog.sv
`timescale 1ns/1ps
module tb_tick_watchdog;
  localparam int T  = 4;
  localparam int M  = 5;
  localparam int P  = 16;
  localparam logic [7:0] A_CTL = 8'hF5;
  localparam logic [7:0] A_CNT = 8'hF6;
  localparam logic [7:0] A_STS = 8'hF7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       kbd_act = 1'b0;
  logic       mouse_act = 1'b0;
  logic       wdt_out_n, kbrst_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tick_watchdog #(.TICK_DIV(T), .SECS_PER_MIN(M), .PULSE_CYCLES(P)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .kbd_act(kbd_act), .mouse_act(mouse_act),
    .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic act(input bit k, input bit m);
    kbd_act = k; mouse_act = m;
    @(negedge clk);
    kbd_act = 1'b0; mouse_act = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk(wdt_out_n == 1'b1, "R1 wdt_out_n", wdt_out_n, 1);
    chk(kbrst_n == 1'b1, "R1 kbrst_n", kbrst_n, 1);
    rd(A_CNT, d); chk(d == 8'h00, "R1 count", d, 0);
    rd(A_CTL, d); chk(d == 8'h00, "R1 control", d, 0);
    rd(A_STS, d); chk(d == 8'h00, "R1 status", d, 0);

    // R9 read map
    wr(A_CTL, 8'hFF); rd(A_CTL, d); chk(d == 8'h0E, "R9 control mask", d, 8'h0E);
    wr(A_CTL, 8'h00);
    wr(A_STS, 8'hFF); rd(A_STS, d); chk(d == 8'hC0, "R9 status mask", d, 8'hC0);
    wr(A_STS, 8'h00);
    rd(8'h00, d); chk(d == 8'h00, "R9 unmapped 00", d, 0);
    rd(8'hF4, d); chk(d == 8'h00, "R9 unmapped F4", d, 0);

    // R2/R4 expiry sweep
    for (int n = 1; n <= 33; n++) begin
      int nn;
      nn = (n == 33) ? 255 : n;
      wr(A_CNT, 8'(nn));
      idle(nn * T - 1);
      chk(wdt_out_n == 1'b1, "R2 before expiry", wdt_out_n, 1);
      idle(1);
      chk(wdt_out_n == 1'b0, "R4 at expiry", wdt_out_n, 0);
      chk(kbrst_n == 1'b1, "R5 no pulse when disabled", kbrst_n, 1);
      rd(A_CNT, d); chk(d == 8'h00, "R4 count holds zero", d, 0);
      rd(A_STS, d); chk(d == 8'h10, "R4 flag set", d, 8'h10);
      wr(A_STS, 8'h00);
      chk(wdt_out_n == 1'b1, "R4 cleared by status", wdt_out_n, 1);
    end

    // R2 remaining-time readback
    wr(A_CNT, 8'd20);
    for (int j = 1; j <= 6; j++) begin
      idle(T - 1);
      rd(A_CNT, d); chk(d == 8'(21 - j), "R2 remaining", d, 21 - j);
    end
    // R2 kick restores value
    wr(A_CNT, 8'd10);
    rd(A_CNT, d); chk(d == 8'd10, "R2 kick reload", d, 10);
    // R3 stop
    wr(A_CNT, 8'd0);
    idle(20 * T);
    chk(wdt_out_n == 1'b1, "R3 no expiry after stop", wdt_out_n, 1);
    rd(A_CNT, d); chk(d == 8'h00, "R3 count zero", d, 0);

    // R10 and R4 clear by kick
    wr(A_CNT, 8'd2);
    idle(2 * T);
    chk(wdt_out_n == 1'b0, "R4 expiry", wdt_out_n, 0);
    wr(A_STS, 8'h10);
    chk(wdt_out_n == 1'b0, "R10 flag kept", wdt_out_n, 0);
    rd(A_STS, d); chk(d == 8'h10, "R10 status flag", d, 8'h10);
    wr(A_CNT, 8'd3);
    chk(wdt_out_n == 1'b1, "R4 cleared by kick", wdt_out_n, 1);
    wr(A_CNT, 8'd0);
    wr(A_STS, 8'h10);
    rd(A_STS, d); chk(d == 8'h00, "R10 no set", d, 0);

    // R5 keyboard-reset pulse
    wr(A_CTL, 8'h02);
    wr(A_CNT, 8'd1);
    idle(T - 1);
    chk(kbrst_n == 1'b1, "R5 before pulse", kbrst_n, 1);
    for (int i = 0; i < P; i++) begin
      idle(1);
      chk(kbrst_n == 1'b0, "R5 pulse low", kbrst_n, 0);
    end
    idle(1);
    chk(kbrst_n == 1'b1, "R5 pulse end", kbrst_n, 1);
    wr(A_CTL, 8'h00); wr(A_STS, 8'h00);

    // R6 minute mode
    wr(A_CTL, 8'h08);
    wr(A_CNT, 8'd2);
    idle(M * T - 1);
    rd(A_CNT, d); chk(d == 8'd2, "R6 count before minute step", d, 2);
    idle(M * T - 1);
    chk(wdt_out_n == 1'b1, "R6 before expiry", wdt_out_n, 1);
    idle(1);
    chk(wdt_out_n == 1'b0, "R6 at expiry", wdt_out_n, 0);
    wr(A_CTL, 8'h00); wr(A_STS, 8'h00);

    // R7 keyboard stop
    wr(A_CTL, 8'h04);
    wr(A_CNT, 8'd50);
    act(1'b1, 1'b0);
    rd(A_CNT, d); chk(d == 8'h00, "R7 stopped", d, 0);
    idle(60 * T);
    chk(wdt_out_n == 1'b1, "R7 no flag", wdt_out_n, 1);
    wr(A_CTL, 8'h00);
    wr(A_CNT, 8'd50);
    act(1'b1, 1'b0);
    rd(A_CNT, d); chk(d == 8'd50, "R7 no stop when disabled", d, 50);
    wr(A_CNT, 8'd0);

    // R8 keyboard reload
    wr(A_STS, 8'h40);
    wr(A_CNT, 8'd3);
    idle(2 * T - 1);
    act(1'b1, 1'b0);
    idle(3 * T - 1);
    chk(wdt_out_n == 1'b1, "R8 kbd reload delays", wdt_out_n, 1);
    idle(1);
    chk(wdt_out_n == 1'b0, "R8 kbd reload expiry", wdt_out_n, 0);
    // R8 mouse reload
    wr(A_STS, 8'h80);
    wr(A_CNT, 8'd3);
    idle(2 * T - 1);
    act(1'b0, 1'b1);
    idle(3 * T - 1);
    chk(wdt_out_n == 1'b1, "R8 mouse reload delays", wdt_out_n, 1);
    idle(1);
    chk(wdt_out_n == 1'b0, "R8 mouse reload expiry", wdt_out_n, 0);
    // R8 no effect when disabled
    wr(A_STS, 8'h00);
    wr(A_CNT, 8'd3);
    idle(2 * T - 1);
    act(1'b1, 1'b1);
    idle(T - 1);
    chk(wdt_out_n == 1'b1, "R8 disabled before expiry", wdt_out_n, 1);
    idle(1);
    chk(wdt_out_n == 1'b0, "R8 disabled no reload", wdt_out_n, 0);
    // R8 no reload of stopped timer
    wr(A_STS, 8'h40);
    act(1'b1, 1'b0);
    rd(A_CNT, d); chk(d == 8'h00, "R8 stopped stays", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule